// File: doc/BRIEF.md
# Paged SRAM Write-Protect Filter

This block sits on the write path between a bus port and a 64 KB SRAM. The SRAM is split into 64 pages of 1 KB, and a 64-bit protection mask holds one bit per page. Software can only set mask bits, by writing two 32-bit registers. Only a system reset clears them. A bus write that targets a protected page never reaches the SRAM. The bus sees a one-cycle error in the same cycle as the dropped write strobe. Reads and writes to unprotected pages pass straight through.

A built-in erase sequencer can take over the SRAM port. It is a three-state machine: `ER_IDLE`, `ER_SWEEP` and `ER_FINISH`. An `erase_req` pulse in `ER_IDLE` moves it to `ER_SWEEP`. In that state it writes zero to every word, one word per cycle, and it ignores the protection mask. After the last word it moves to `ER_FINISH` for one cycle, which raises `erase_done`, and then returns to `ER_IDLE`. While the sequencer owns the port, bus requests are neither forwarded nor errored, and the bus master is expected to hold off.

Top module: `wp_filter`

## Requirements
- R1: After reset, both mask registers read 0, and `erase_busy`, `erase_done` and `bus_err` are low.
- R2: When `cfg_wr_en` is high, every 1 in `cfg_wdata` sets the matching mask bit. Select 0 holds pages 0 to 31 and select 1 holds pages 32 to 63; bit n of a register covers page 32*select+n. `cfg_rdata` always shows the register chosen by `cfg_sel`.
- R3: Zeros written to a mask register have no effect. Mask bits clear only on reset.
- R4: The page of a bus access is byte-address bits 15:10.
- R5: A bus write to a protected page keeps `sram_we` low and raises `bus_err` in the same cycle as the strobe. `bus_err` is never raised without a bus write.
- R6: A bus write to an unprotected page drives `sram_en` and `sram_we` high, with `sram_addr` set to byte address bits 15:2, `sram_wdata` and `sram_be` passed through unchanged, and `bus_err` low.
- R7: A bus read is always forwarded with `sram_en` high and `sram_we` low, and never raises `bus_err`, whatever the mask holds.
- R8: `erase_req` in idle starts a sweep on the next cycle. `erase_busy` stays high for exactly 16384 cycles. Each of those cycles writes zero with all byte enables to word address 0, 1, and so on up to 16383, protected pages included.
- R9: In the cycle after the sweep ends, `erase_done` is high for exactly one cycle and `erase_busy` is low.
- R10: During a sweep, bus requests are not forwarded and raise no `bus_err`, and a further `erase_req` is ignored.
- R11: An erase leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| cfg_wr_en | input | 1 | Mask register write strobe |
| cfg_sel | input | 1 | Mask register select (0: pages 0-31, 1: pages 32-63) |
| cfg_wdata | input | 32 | Mask write data, ones set bits |
| cfg_rdata | output | 32 | Selected mask register |
| bus_valid | input | 1 | Bus access strobe |
| bus_we | input | 1 | Bus access is a write |
| bus_addr | input | 16 | Bus byte offset |
| bus_wdata | input | 32 | Bus write data |
| bus_be | input | 4 | Bus byte enables |
| bus_err | output | 1 | Error for a dropped protected write |
| erase_req | input | 1 | Erase start pulse |
| erase_busy | output | 1 | Sweep in progress |
| erase_done | output | 1 | One-cycle end-of-erase pulse |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 14 | SRAM word address |
| sram_wdata | output | 32 | SRAM write data |
| sram_be | output | 4 | SRAM byte enables |

## Verification
The hardest case to reach from the ports is a bus write to a protected page that arrives during a sweep. Outside a sweep that write must raise an error. During a sweep it must be dropped silently, and the sweep must keep its address sequence without a break. To get there, the stimulus first sets a sparse mask pattern and fires an erase. Partway through the sweep it holds a write to a protected page on the bus and checks that there is no error, that the address steps once per cycle, and that the data stays zero. It also sends a second `erase_req` during the sweep and checks that the total length is still 16384 cycles.

// File: rtl/wp_pkg.sv
package wp_pkg;
    typedef enum logic [1:0] {
        ER_IDLE   = 2'd0,
        ER_SWEEP  = 2'd1,
        ER_FINISH = 2'd2
    } erase_st_e;
endpackage

// File: rtl/wp_mask_regs.sv
module wp_mask_regs #(
    parameter int PAGES = 64,
    parameter int REG_W = 32,
    localparam int NREGS = PAGES / REG_W,
    localparam int SEL_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic [PAGES-1:0] mask
);
    // Set-only storage: ones are OR-ed in, only reset clears.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (cfg_wr_en) begin
            for (int r = 0; r < NREGS; r++) begin
                if (cfg_sel == SEL_W'(r))
                    mask[r*REG_W +: REG_W] <= mask[r*REG_W +: REG_W] | cfg_wdata;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int r = 0; r < NREGS; r++) begin
            if (cfg_sel == SEL_W'(r))
                cfg_rdata = mask[r*REG_W +: REG_W];
        end
    end
endmodule

// File: rtl/wp_page_guard.sv
module wp_page_guard #(
    parameter int PAGES      = 64,
    parameter int PAGE_BYTES = 1024,
    localparam int PIDX_W = $clog2(PAGES),
    localparam int OFS_W  = $clog2(PAGE_BYTES),
    localparam int ADDR_W = PIDX_W + OFS_W
) (
    input  logic [PAGES-1:0]  mask,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              pass_en,
    output logic              pass_we,
    output logic              reject
);
    logic [PIDX_W-1:0] page;
    logic              locked;

    assign page   = bus_addr[ADDR_W-1:OFS_W];
    assign locked = mask[page];

    always_comb begin
        pass_en = bus_valid;
        pass_we = bus_valid && bus_we && !locked;
        reject  = bus_valid && bus_we && locked;
    end
endmodule

// File: rtl/wp_erase_seq.sv
module wp_erase_seq
    import wp_pkg::*;
#(
    parameter int WORDS = 16384,
    localparam int WA_W = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            erase_req,
    output logic            busy,
    output logic            done,
    output logic [WA_W-1:0] ers_addr
);
    erase_st_e          st_q, st_d;
    logic [WA_W-1:0]    cnt_q;
    logic               last;

    assign last = (cnt_q == WA_W'(WORDS - 1));

    // State register and word counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ER_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= (st_q == ER_SWEEP && !last) ? cnt_q + 1'b1 : '0;
        end
    end

    // Next state.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ER_IDLE:   if (erase_req) st_d = ER_SWEEP;
            ER_SWEEP:  if (last)      st_d = ER_FINISH;
            ER_FINISH:                st_d = ER_IDLE;
            default:                  st_d = ER_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        busy     = 1'b0;
        done     = 1'b0;
        ers_addr = cnt_q;
        unique case (st_q)
            ER_IDLE:   ;
            ER_SWEEP:  busy = 1'b1;
            ER_FINISH: done = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/wp_filter.sv
module wp_filter #(
    parameter int PAGES      = 64,
    parameter int PAGE_BYTES = 1024,
    parameter int REG_W      = 32,
    parameter int DATA_W     = 32,
    localparam int BE_W   = DATA_W / 8,
    localparam int NREGS  = PAGES / REG_W,
    localparam int SEL_W  = (NREGS > 1) ? $clog2(NREGS) : 1,
    localparam int ADDR_W = $clog2(PAGES) + $clog2(PAGE_BYTES),
    localparam int LSB_W  = $clog2(BE_W),
    localparam int WORDS  = PAGES * PAGE_BYTES / BE_W,
    localparam int WA_W   = ADDR_W - LSB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [BE_W-1:0]   bus_be,
    output logic              bus_err,
    input  logic              erase_req,
    output logic              erase_busy,
    output logic              erase_done,
    output logic              sram_en,
    output logic              sram_we,
    output logic [WA_W-1:0]   sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    output logic [BE_W-1:0]   sram_be
);
    logic [PAGES-1:0] mask;
    logic             pass_en, pass_we, reject;
    logic [WA_W-1:0]  ers_addr;

    wp_mask_regs #(.PAGES(PAGES), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mask(mask)
    );

    wp_page_guard #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_guard (
        .mask(mask), .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .pass_en(pass_en), .pass_we(pass_we), .reject(reject)
    );

    wp_erase_seq #(.WORDS(WORDS)) u_erase (
        .clk(clk), .rst_n(rst_n), .erase_req(erase_req),
        .busy(erase_busy), .done(erase_done), .ers_addr(ers_addr)
    );

    // Port arbitration: the sweep wins and bypasses the mask.
    always_comb begin
        if (erase_busy) begin
            sram_en    = 1'b1;
            sram_we    = 1'b1;
            sram_addr  = ers_addr;
            sram_wdata = '0;
            sram_be    = '1;
            bus_err    = 1'b0;
        end else begin
            sram_en    = pass_en;
            sram_we    = pass_we;
            sram_addr  = bus_addr[ADDR_W-1:LSB_W];
            sram_wdata = bus_wdata;
            sram_be    = bus_be;
            bus_err    = reject;
        end
    end
endmodule

// File: rtl/wp_filter_chk.sv
module wp_filter_chk #(
    parameter int PAGES = 64,
    parameter int WA_W  = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PAGES-1:0] mask,
    input logic             bus_valid,
    input logic             bus_we,
    input logic             bus_err,
    input logic             sram_we,
    input logic [WA_W-1:0]  sram_addr,
    input logic             erase_busy,
    input logic             erase_done
);
    // R3: mask bits never clear outside reset
    a_r3_mask_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask & $past(mask)) == $past(mask)));

    // R5: an error blocks the SRAM write strobe
    a_r5_err_blocks_we: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> !sram_we);

    // R5: an error only answers a bus write
    a_r5_err_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_valid && bus_we));

    // R10: no error while sweeping
    a_r10_quiet_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy |-> !bus_err);

    // R8: sweep address advances by one per cycle
    a_r8_sweep_step: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_busy && $past(erase_busy)) |-> (sram_addr == $past(sram_addr) + 1'b1));

    // R9: done follows the sweep and lasts one cycle
    a_r9_done_after_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |-> ($past(erase_busy) && !erase_busy));
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |=> !erase_done);
endmodule

bind wp_filter wp_filter_chk #(.PAGES(PAGES), .WA_W(WA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mask(mask), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_err(bus_err), .sram_we(sram_we), .sram_addr(sram_addr),
    .erase_busy(erase_busy), .erase_done(erase_done)
);

// File: tb/sim_wp_filter.sv
`timescale 1ns/1ps
module sim_wp_filter;
    localparam int WORDS = 16384;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_wr_en = 0;
    logic        cfg_sel = 0;
    logic [31:0] cfg_wdata = 0;
    logic [31:0] cfg_rdata;
    logic        bus_valid = 0, bus_we = 0;
    logic [15:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [3:0]  bus_be = 0;
    logic        bus_err;
    logic        erase_req = 0;
    logic        erase_busy, erase_done;
    logic        sram_en, sram_we;
    logic [13:0] sram_addr;
    logic [31:0] sram_wdata;
    logic [3:0]  sram_be;

    int n_vec = 0;
    int n_bad = 0;
    logic [63:0] model = '0;

    always #4 clk = ~clk;

    wp_filter u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 0;
        if (sel) model[63:32] = model[63:32] | d;
        else     model[31:0]  = model[31:0]  | d;
    endtask

    task automatic check_mask(input string req);
        @(negedge clk);
        cfg_sel = 0; #1; chk(req, cfg_rdata, model[31:0]);
        cfg_sel = 1; #1; chk(req, cfg_rdata, model[63:32]);
    endtask

    // R4 R5 R6 R7: every page at three offsets, write then read
    task automatic page_sweep();
        logic [9:0] offs [3] = '{10'h000, 10'h200, 10'h3FC};
        for (int p = 0; p < 64; p++) begin
            for (int k = 0; k < 3; k++) begin
                logic [15:0] a;
                logic [31:0] d;
                logic        prot;
                a = {p[5:0], offs[k]};
                d = 32'h1234_0000 ^ {16'd0, a};
                prot = model[p];
                @(negedge clk);
                bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = 4'b1010;
                #2;
                chk("R5 err", bus_err, prot);
                chk("R6 we", sram_we, !prot);
                if (!prot) begin
                    chk("R6 addr", sram_addr, a[15:2]);
                    chk("R6 data", {sram_be, sram_wdata}, {4'b1010, d});
                end
                @(negedge clk);
                bus_we = 0;
                #2;
                chk("R7 rd", {sram_en, sram_we, bus_err}, 3'b100);
                bus_valid = 0;
            end
        end
    endtask

    initial begin : watchdog
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 flags", {erase_busy, erase_done, bus_err}, 3'b000);
        check_mask("R1 mask");

        cfg_write(0, 32'hA5A5_0F0F);
        cfg_write(1, 32'h8000_0001);
        check_mask("R2 set");
        cfg_write(0, 32'h0);
        cfg_write(1, 32'h0);
        check_mask("R3 zeros ignored");
        page_sweep();

        cfg_write(1, 32'h0000_FF00);
        cfg_write(0, 32'h0000_0040);
        check_mask("R2 accumulate");
        page_sweep();

        // R8 R10: erase with a protected write held and a repeat request
        @(negedge clk);
        erase_req = 1;
        @(negedge clk);
        erase_req = 0;
        begin
            int cyc = 0;
            int bad = 0;
            #2;
            while (erase_busy && cyc < WORDS + 10) begin
                if (sram_addr != cyc[13:0] || !sram_we || !sram_en ||
                    sram_wdata != 0 || sram_be != 4'hF || bus_err) bad++;
                @(negedge clk);
                if (cyc == 100) begin
                    bus_valid = 1; bus_we = 1; bus_addr = 16'h0000; erase_req = 1;
                end
                if (cyc == 103) begin
                    bus_valid = 0; bus_we = 0; erase_req = 0;
                end
                cyc++;
                #2;
            end
            chk("R8 length", cyc, WORDS);
            chk("R8 R10 sweep beats", bad, 0);
            chk("R9 done", {erase_done, erase_busy}, 2'b10);
            @(negedge clk); #2;
            chk("R9 single", erase_done, 1'b0);
        end
        check_mask("R11 mask kept");
        page_sweep();

        // R3: reset clears mask
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        model = '0;
        check_mask("R3 reset clears");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule